// File: doc/BRIEF.md
# Prefetch Candidate Queue

This block sits beside a cache and holds block addresses that a separate address generator has proposed for prefetching. Each cycle it may take a small batch of candidates, and each candidate carries a delay in cycles. It stamps every candidate with the cycle in which that candidate becomes eligible. Candidates leave strictly oldest first through a valid/ready issue port, and only once their stamp has been reached. A combinational probe port shows the head block to the cache. If the cache already holds that block, or already has a miss outstanding for it, the head is thrown away instead of being issued.

A training port observes demand accesses. Configuration inputs decide which accesses train: instruction fetches, data reads, data writes, and optionally only accesses that missed both the cache and the miss queue. An access that trains cancels any queued copy of its own block. In serial-squash mode it also clears recently stamped entries from the tail of the queue. Addresses are handled at cache-block granularity, and the secure bit is part of every match.

Top module: `pfq_buffer`

## Requirements
- R1: An access with trn_uncached=1 never trains: it removes and squashes nothing.
- R2: A fetch (trn_fetch=1) trains only when cfg_inst_en=1. A data access trains only when its enable is set: cfg_write_en for trn_write=1, cfg_read_en for trn_write=0.
- R3: With cfg_miss_only=1, an access trains only if trn_cache_hit=0 and trn_mq_hit=0.
- R4: The block address is the address with its low log2(BLK_BYTES) bits cleared (bits [5:0] at the default of 64). iss_addr and probe_addr always carry block addresses. Two entries match only when both block address and secure bit are equal.
- R5: An access that trains removes the queued entry of the same block and secure bit. An entry whose secure bit differs stays.
- R6: With cfg_serial_squash=1, an access that trains walks from the tail toward the head. It removes each entry whose ready time is at or after the current cycle and stops at the first entry with an earlier ready time.
- R7: A candidate matching an entry already queued, or an earlier candidate of the same batch (cand_valid bit 0 is taken before bit 1), is discarded. The queue never holds duplicates.
- R8: A candidate accepted into a full queue of DEPTH entries evicts the head and is appended at the tail.
- R9: A candidate accepted in cycle T with delay d gets ready time T+d. iss_valid rises only when the head's ready time is not later than the free-running cycle count, and entries leave in insertion order.
- R10: When the head is ready and probe_hit=1, the head is dropped without being issued, at most one entry per cycle. iss_valid stays low while the queue is empty.
- R11: Within one cycle, training removals and squashes come first, then the head issue or drop, then candidate insertion. A head removed by training is not issued, and a candidate equal to the head being popped is accepted.
- R12: After reset the queue is empty and iss_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_inst_en | input | 1 | Instruction fetches may train |
| cfg_read_en | input | 1 | Data reads may train |
| cfg_write_en | input | 1 | Data writes may train |
| cfg_miss_only | input | 1 | Train only on accesses missing cache and miss queue |
| cfg_serial_squash | input | 1 | Training squashes newer entries from the tail |
| trn_valid | input | 1 | Demand access present |
| trn_addr | input | AW | Demand access address |
| trn_secure | input | 1 | Demand access secure bit |
| trn_fetch | input | 1 | Access is an instruction fetch |
| trn_write | input | 1 | Data access is a write |
| trn_uncached | input | 1 | Access is uncacheable |
| trn_cache_hit | input | 1 | Access hit in the cache |
| trn_mq_hit | input | 1 | Access hit in the miss queue |
| cand_valid | input | NCAND | Candidate valid, bit 0 first |
| cand_addr | input | NCAND*AW | Candidate addresses, candidate c at [c*AW +: AW] |
| cand_delay | input | NCAND*DW | Candidate delays in cycles, candidate c at [c*DW +: DW] |
| cand_secure | input | 1 | Secure bit for this cycle's candidates |
| probe_addr | output | AW | Head block address shown to the cache |
| probe_secure | output | 1 | Head secure bit shown to the cache |
| probe_hit | input | 1 | Head block is cached or already in flight |
| iss_valid | output | 1 | Head is ready and not present downstream |
| iss_ready | input | 1 | Consumer takes the head |
| iss_addr | output | AW | Issued block address |
| iss_secure | output | 1 | Issued secure bit |

## Verification
The bench targets the edges of each cancellation rule. It trains on the same block with the other secure bit, and on accesses that one of the enables or the miss-only filter should reject. A design that ignored the secure bit or one of the filters would lose an entry that must later be issued. The squash case places an older entry between two newer ones, so a walk that did not stop would also remove the head. Same-cycle cases pop the head while re-offering its block, and train on the head while the consumer is ready. A wrong update order there shows up as a missing issue or a stale one. The overflow sweep fills the queue one entry past its depth, and a design that evicted the tail or refused the newcomer gives the wrong issue sequence.

// File: rtl/pfq_buffer.sv
module pfq_buffer #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 8,
  parameter int NCAND     = 2,
  parameter int DW        = 4,
  parameter int TW        = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_inst_en,
  input  logic                  cfg_read_en,
  input  logic                  cfg_write_en,
  input  logic                  cfg_miss_only,
  input  logic                  cfg_serial_squash,
  input  logic                  trn_valid,
  input  logic [AW-1:0]         trn_addr,
  input  logic                  trn_secure,
  input  logic                  trn_fetch,
  input  logic                  trn_write,
  input  logic                  trn_uncached,
  input  logic                  trn_cache_hit,
  input  logic                  trn_mq_hit,
  input  logic [NCAND-1:0]      cand_valid,
  input  logic [NCAND*AW-1:0]   cand_addr,
  input  logic [NCAND*DW-1:0]   cand_delay,
  input  logic                  cand_secure,
  output logic [AW-1:0]         probe_addr,
  output logic                  probe_secure,
  input  logic                  probe_hit,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [AW-1:0]         iss_addr,
  output logic                  iss_secure
);
  localparam int OFS = $clog2(BLK_BYTES);
  localparam int BW  = AW - OFS;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [BW-1:0] q_blk [DEPTH];
  logic          q_sec [DEPTH];
  logic [TW-1:0] q_rdy [DEPTH];
  logic [CW-1:0] cnt;
  logic [TW-1:0] now;

  logic [BW-1:0] n_blk [DEPTH];
  logic          n_sec [DEPTH];
  logic [TW-1:0] n_rdy [DEPTH];
  logic [CW-1:0] n_cnt;

  logic [DEPTH-1:0] keep, live;
  logic trn_take, head_rdy, drop, pop;

  wire [BW-1:0] trn_blk = trn_addr[AW-1:OFS];

  assign trn_take = trn_valid && !trn_uncached
                 && (trn_fetch ? cfg_inst_en : (trn_write ? cfg_write_en : cfg_read_en))
                 && !(cfg_miss_only && (trn_cache_hit || trn_mq_hit));

  always_comb begin : kill
    logic stop;
    stop = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      keep[i] = (CW'(i) < cnt) && !(trn_take && q_blk[i] == trn_blk && q_sec[i] == trn_secure);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (trn_take && cfg_serial_squash && keep[i] && !stop) begin
        if (q_rdy[i] >= now) keep[i] = 1'b0;
        else stop = 1'b1;
      end
  end

  assign head_rdy     = keep[0] && (q_rdy[0] <= now);
  assign probe_addr   = {q_blk[0], {OFS{1'b0}}};
  assign probe_secure = q_sec[0];
  assign iss_valid    = head_rdy && !probe_hit;
  assign iss_addr     = probe_addr;
  assign iss_secure   = q_sec[0];
  assign drop         = head_rdy && probe_hit;
  assign pop          = iss_valid && iss_ready;
  assign live         = keep & ~{{(DEPTH-1){1'b0}}, (drop || pop)};

  always_comb begin : pack
    logic [CW-1:0] n;
    logic          dup;
    logic [BW-1:0] cb;
    n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_blk[i] = '0;
      n_sec[i] = 1'b0;
      n_rdy[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++)
      if (live[i]) begin
        n_blk[n[IW-1:0]] = q_blk[i];
        n_sec[n[IW-1:0]] = q_sec[i];
        n_rdy[n[IW-1:0]] = q_rdy[i];
        n = n + 1'b1;
      end
    for (int c = 0; c < NCAND; c++) begin
      cb  = cand_addr[c*AW+OFS +: BW];
      dup = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (CW'(j) < n && n_blk[j] == cb && n_sec[j] == cand_secure) dup = 1'b1;
      if (cand_valid[c] && !dup) begin
        if (n == CW'(DEPTH)) begin
          for (int j = 0; j < DEPTH - 1; j++) begin
            n_blk[j] = n_blk[j+1];
            n_sec[j] = n_sec[j+1];
            n_rdy[j] = n_rdy[j+1];
          end
          n = n - 1'b1;
        end
        n_blk[n[IW-1:0]] = cb;
        n_sec[n[IW-1:0]] = cand_secure;
        n_rdy[n[IW-1:0]] = now + TW'(cand_delay[c*DW +: DW]);
        n = n + 1'b1;
      end
    end
    n_cnt = n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      now <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_blk[i] <= '0;
        q_sec[i] <= 1'b0;
        q_rdy[i] <= '0;
      end
    end else begin
      cnt <= n_cnt;
      now <= now + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        q_blk[i] <= n_blk[i];
        q_sec[i] <= n_sec[i];
        q_rdy[i] <= n_rdy[i];
      end
    end
  end
endmodule

// File: rtl/pfq_buffer_chk.sv
module pfq_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int NCAND = 2,
  parameter int BW    = 26,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trn_valid,
  input logic             trn_uncached,
  input logic [NCAND-1:0] cand_valid,
  input logic             probe_hit,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [CW-1:0]    cnt,
  input logic [BW-1:0]    q_blk [DEPTH],
  input logic             q_sec [DEPTH]
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !iss_valid);

  // R1
  uncached_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && trn_uncached && cand_valid == '0 && !probe_hit && !iss_ready)
      |=> cnt == $past(cnt));

  // R9
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !trn_valid && cand_valid == '0)
      |=> cnt == $past(cnt) - CW'(1));

  for (genvar i = 0; i < DEPTH; i++) begin : g_a
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_b
      // R7
      no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(j) < cnt) |-> !(q_blk[i] == q_blk[j] && q_sec[i] == q_sec[j]));
    end
  end
endmodule

bind pfq_buffer pfq_buffer_chk #(.DEPTH(DEPTH), .NCAND(NCAND), .BW(BW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trn_valid(trn_valid), .trn_uncached(trn_uncached),
  .cand_valid(cand_valid), .probe_hit(probe_hit), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .cnt(cnt), .q_blk(q_blk), .q_sec(q_sec)
);

// File: tb/sim_pfq_buffer.sv
`timescale 1ns/1ps
module sim_pfq_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_inst_en = 1'b1, cfg_read_en = 1'b1, cfg_write_en = 1'b1;
  logic cfg_miss_only = 1'b0, cfg_serial_squash = 1'b0;
  logic trn_valid = 1'b0, trn_secure = 1'b0, trn_fetch = 1'b0, trn_write = 1'b0;
  logic trn_uncached = 1'b0, trn_cache_hit = 1'b0, trn_mq_hit = 1'b0;
  logic [31:0] trn_addr = '0;
  logic [1:0]  cand_valid = '0;
  logic [63:0] cand_addr = '0;
  logic [7:0]  cand_delay = '0;
  logic cand_secure = 1'b0, probe_hit = 1'b0, iss_ready = 1'b0;
  logic [31:0] probe_addr, iss_addr;
  logic probe_secure, iss_valid, iss_secure;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfq_buffer u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic push1(logic [31:0] a, logic [3:0] d, logic s);
    cand_valid = 2'b01; cand_addr[31:0] = a; cand_delay[3:0] = d; cand_secure = s;
    @(negedge clk);
    cand_valid = '0;
  endtask

  task automatic push2(logic [31:0] a0, logic [3:0] d0, logic [31:0] a1, logic [3:0] d1);
    cand_valid = 2'b11; cand_addr = {a1, a0}; cand_delay = {d1, d0}; cand_secure = 1'b0;
    @(negedge clk);
    cand_valid = '0;
  endtask

  task automatic pop(string tag, logic [31:0] exp, logic s = 1'b0);
    for (int k = 0; k < 40 && !iss_valid; k++) @(negedge clk);
    chk({tag, " valid"}, iss_valid, 1);
    chk({tag, " addr"}, {iss_secure, iss_addr}, {s, exp});
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic train(logic [31:0] a, logic s, logic f, logic w, logic u, logic ch, logic mh);
    trn_valid = 1'b1; trn_addr = a; trn_secure = s; trn_fetch = f; trn_write = w;
    trn_uncached = u; trn_cache_hit = ch; trn_mq_hit = mh;
    @(negedge clk);
    trn_valid = 1'b0; trn_uncached = 1'b0; trn_cache_hit = 1'b0; trn_mq_hit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset idle", iss_valid, 0);

    // R4 alignment, R9 delay 0
    push1(32'h1234_5678, 0, 0);
    chk("R4 probe aligned", probe_addr, 32'h1234_5640);
    pop("R4 issue aligned", 32'h1234_5640);
    chk("R10 empty after pop", iss_valid, 0);

    // R9 ready time
    push1(32'h0000_3000, 5, 0);
    chk("R9 not ready +1", iss_valid, 0);
    repeat (3) @(negedge clk);
    chk("R9 not ready +4", iss_valid, 0);
    @(negedge clk);
    chk("R9 ready +5", iss_valid, 1);
    pop("R9 delayed", 32'h0000_3000);

    // R9 order within a batch
    push2(32'h0000_4000, 0, 32'h0000_4100, 0);
    pop("R9 order first", 32'h0000_4000);
    pop("R9 order second", 32'h0000_4100);

    // R8 overflow sweep
    for (int i = 0; i < 9; i++) push1(32'h2000 + i * 32'h40, 0, 0);
    for (int i = 1; i < 9; i++) pop("R8 evict oldest", 32'h2000 + i * 32'h40);
    chk("R8 drained", iss_valid, 0);

    // R7 duplicates
    push1(32'h5000, 0, 0);
    push2(32'h5010, 0, 32'h5200, 0);
    push2(32'h5400, 0, 32'h5404, 0);
    push1(32'h5600, 0, 0);
    push1(32'h5600, 0, 1);
    pop("R7 dup queued", 32'h5000);
    pop("R7 new kept", 32'h5200);
    pop("R7 batch dup", 32'h5400);
    pop("R7 sec0", 32'h5600, 0);
    pop("R7 sec1 distinct", 32'h5600, 1);
    chk("R7 no extra", iss_valid, 0);

    // R5 removal with and without secure match
    push2(32'h6000, 0, 32'h6100, 0);
    train(32'h6103, 0, 0, 0, 0, 0, 0);
    train(32'h6000, 1, 0, 0, 0, 0, 0);
    pop("R5 other secure kept", 32'h6000);
    chk("R5 matched removed", iss_valid, 0);

    // R1 uncached
    push1(32'h7000, 0, 0);
    train(32'h7000, 0, 0, 0, 1, 0, 0);
    pop("R1 uncached ignored", 32'h7000);

    // R2 enables
    push1(32'h7100, 0, 0);
    cfg_inst_en = 1'b0;
    train(32'h7100, 0, 1, 0, 0, 0, 0);
    cfg_write_en = 1'b0;
    train(32'h7100, 0, 0, 1, 0, 0, 0);
    pop("R2 disabled ignored", 32'h7100);
    push1(32'h7200, 0, 0);
    cfg_inst_en = 1'b1;
    train(32'h7200, 0, 1, 0, 0, 0, 0);
    chk("R2 fetch trains", iss_valid, 0);
    push1(32'h7300, 0, 0);
    train(32'h7300, 0, 0, 0, 0, 0, 0);
    chk("R2 read trains", iss_valid, 0);
    cfg_write_en = 1'b1;

    // R3 miss only
    cfg_miss_only = 1'b1;
    push1(32'h8000, 0, 0);
    train(32'h8000, 0, 0, 0, 0, 1, 0);
    train(32'h8000, 0, 0, 0, 0, 0, 1);
    chk("R3 hits ignored", iss_valid, 1);
    train(32'h8000, 0, 0, 0, 0, 0, 0);
    chk("R3 miss trains", iss_valid, 0);
    cfg_miss_only = 1'b0;

    // R6 serial squash stops at first older entry
    push1(32'h9000, 15, 0);
    push1(32'h9100, 0, 0);
    push1(32'h9200, 15, 0);
    cfg_serial_squash = 1'b1;
    train(32'h00FF_F000, 0, 0, 0, 0, 0, 0);
    cfg_serial_squash = 1'b0;
    pop("R6 head survives", 32'h9000);
    pop("R6 older survives", 32'h9100);
    chk("R6 newer squashed", iss_valid, 0);

    // R10 probe drop
    push2(32'hA000, 0, 32'hA100, 0);
    chk("R10 probe head", probe_addr, 32'hA000);
    probe_hit = 1'b1;
    #1 chk("R10 hit blocks issue", iss_valid, 0);
    @(negedge clk);
    probe_hit = 1'b0;
    pop("R10 next after drop", 32'hA100);
    chk("R10 empty", iss_valid, 0);

    // R11 pop then re-insert same block
    push1(32'hB000, 0, 0);
    iss_ready = 1'b1; cand_valid = 2'b01; cand_addr[31:0] = 32'hB000; cand_delay[3:0] = 0;
    @(negedge clk);
    iss_ready = 1'b0; cand_valid = '0;
    pop("R11 reinsert after pop", 32'hB000);

    // R11 removal beats issue
    push1(32'hB100, 0, 0);
    iss_ready = 1'b1;
    trn_valid = 1'b1; trn_addr = 32'hB100; trn_secure = 0; trn_fetch = 0; trn_write = 0;
    #1 chk("R11 removed head not issued", iss_valid, 0);
    @(negedge clk);
    iss_ready = 1'b0; trn_valid = 1'b0;
    chk("R11 queue empty", iss_valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog act hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule